// File: doc/BRIEF.md
# Masked-Write Indirect PHY Configuration Bridge

This block is a two-register slave on a simple single-cycle register bus. It turns writes to its control register into write transactions on a narrow indirect configuration port of a PHY. That port has a 6-bit address, 4-bit write data, a one-cycle write pulse and 4-bit read data. Every write to the control register is bit-masked. The upper half of the 32-bit write word gives a per-bit enable for the lower half. Software can therefore change the address and data fields without touching the strobe bit, and the other way round.

A configuration write is a sequence of three bus writes. The first loads the address and data with the strobe low. The second raises the strobe. The third clears the strobe. The block issues exactly one write pulse to the PHY, on the rising edge of the strobe bit. A separate status register returns the PHY's read data for whatever address the control register holds at that moment. Register reads return their data one cycle after the read request.

Top module: `phy_cfg_bridge`

## Requirements
- R1: After reset the control register is zero. The PHY address, write data and write pulse outputs are zero, and the bus read data is zero.
- R2: A write to the control offset 0xE220 changes bit i of the stored control value, for i in 0..15, only when write-data bit 16+i is set. That bit then takes the value of write-data bit i, and every other bit keeps its value.
- R3: The control fields drive the PHY port from the stored value. Bit 0 is the strobe, bits [6:1] are the PHY address and bits [10:7] are the PHY write data.
- R4: The write pulse goes high for exactly one cycle. It appears in the cycle after the bus write that takes the strobe bit from 0 to 1.
- R5: While the strobe bit stays 1, no further write pulse is issued. This holds across idle cycles and across writes that rewrite the strobe as 1.
- R6: A read of the status offset 0xE2A4 returns, one cycle later, the PHY read data for the current control address in bits [11:8]. All other bits of the result read as zero.
- R7: A read of the control offset returns, one cycle later, the stored 16-bit control value in bits [15:0], with bits [31:16] reading as zero.
- R8: A write to any offset other than 0xE220 leaves the control register unchanged and issues no pulse. A read of an unknown offset returns zero.
- R9: A write with enable mask 0x07FE loads the address and data fields and leaves the strobe bit and the pulse output untouched, even when the strobe is already 1.
- R10: Bus read data holds its last value in cycles without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Register write request |
| rd_valid_i | input | 1 | Register read request |
| offset_i | input | 16 | Register offset |
| wdata_i | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| rdata_o | output | 32 | Read data, valid one cycle after rd_valid_i |
| phy_addr_o | output | 6 | PHY configuration address |
| phy_wdata_o | output | 4 | PHY configuration write data |
| phy_we_o | output | 1 | One-cycle PHY configuration write pulse |
| phy_rdata_i | input | 4 | PHY configuration read data for phy_addr_o |

## Verification
Every one of the 64 PHY addresses gets a full load, raise and clear write sequence with a data nibble derived from the address. Each address is then read back through the status register against a PHY model. The model has special read behaviour at addresses 0x10 and 0x12, so a wrong address or data field shows up as a mismatch. The masked-write logic is swept over all 16 enables of each control bit, with data patterns built from the loop index, against a shadow value kept in the bench. Pulses are counted on every rising strobe in the shadow, which separates edge detection from level detection. Writes with the strobe held high, field-only writes with mask 0x07FE and accesses at foreign offsets show that these writes do not disturb the strobe or the stored fields.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned HALF_W = BUS_W / 2;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned PA_W   = 6;
  localparam int unsigned PD_W   = 4;

  localparam logic [OFF_W-1:0] CTRL_OFF = 16'hE220;
  localparam logic [OFF_W-1:0] STAT_OFF = 16'hE2A4;

  // control field layout (decoded by the PHY side, keep fixed)
  localparam int unsigned STB_BIT  = 0;
  localparam int unsigned ADDR_LSB = 1;
  localparam int unsigned DATA_LSB = ADDR_LSB + PA_W;
  // status read field
  localparam int unsigned RD_LSB   = 8;
endpackage

// File: rtl/pcb_mask_reg.sv
module pcb_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[i] <= 1'b0;
      else if (we_i && en_i[i])   q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/pcb_rise_pulse.sv
module pcb_rise_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/pcb_rd_port.sv
module pcb_rd_port #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned PD_W   = 4,
  parameter int unsigned RD_LSB = 8,
  parameter logic [OFF_W-1:0] CTRL_OFF = '0,
  parameter logic [OFF_W-1:0] STAT_OFF = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [HALF_W-1:0] ctrl_i,
  input  logic [PD_W-1:0]   phy_rdata_i,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [BUS_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (offset_i == CTRL_OFF)      rd_mux[HALF_W-1:0]          = ctrl_i;
    else if (offset_i == STAT_OFF) rd_mux[RD_LSB +: PD_W]      = phy_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdata_o <= '0;
    else if (rd_valid_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/phy_cfg_bridge.sv
module phy_cfg_bridge
  import pcb_pkg::*;
#(
  parameter int unsigned BUS_W_P = BUS_W,
  parameter int unsigned OFF_W_P = OFF_W,
  parameter int unsigned PA_W_P  = PA_W,
  parameter int unsigned PD_W_P  = PD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic               rd_valid_i,
  input  logic [OFF_W_P-1:0] offset_i,
  input  logic [BUS_W_P-1:0] wdata_i,
  output logic [BUS_W_P-1:0] rdata_o,
  output logic [PA_W_P-1:0]  phy_addr_o,
  output logic [PD_W_P-1:0]  phy_wdata_o,
  output logic               phy_we_o,
  input  logic [PD_W_P-1:0]  phy_rdata_i
);
  localparam int unsigned HW  = BUS_W_P / 2;
  localparam int unsigned DLSB = ADDR_LSB + PA_W_P;

  logic          ctrl_we;
  logic [HW-1:0] ctrl_q;

  assign ctrl_we = wr_valid_i && (offset_i == CTRL_OFF);

  pcb_mask_reg #(.W(HW)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (ctrl_we),
    .en_i  (wdata_i[BUS_W_P-1:HW]),
    .d_i   (wdata_i[HW-1:0]),
    .q_o   (ctrl_q)
  );

  assign phy_addr_o  = ctrl_q[ADDR_LSB +: PA_W_P];
  assign phy_wdata_o = ctrl_q[DLSB +: PD_W_P];

  pcb_rise_pulse u_stb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ctrl_q[STB_BIT]),
    .pulse_o(phy_we_o)
  );

  pcb_rd_port #(
    .BUS_W   (BUS_W_P),
    .HALF_W  (HW),
    .OFF_W   (OFF_W_P),
    .PD_W    (PD_W_P),
    .RD_LSB  (RD_LSB),
    .CTRL_OFF(CTRL_OFF),
    .STAT_OFF(STAT_OFF)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_valid_i (rd_valid_i),
    .offset_i   (offset_i),
    .ctrl_i     (ctrl_q),
    .phy_rdata_i(phy_rdata_i),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/pcb_bridge_chk.sv
module pcb_bridge_chk
  import pcb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             rd_valid_i,
  input logic [OFF_W-1:0] offset_i,
  input logic [BUS_W-1:0] rdata_o,
  input logic [PA_W-1:0]  phy_addr_o,
  input logic [PD_W-1:0]  phy_wdata_o,
  input logic             phy_we_o
);
  // R4: pulse never lasts two cycles
  p_pulse_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_we_o |=> !phy_we_o);

  // R4/R5: a pulse needs a control write in the previous cycle
  p_pulse_after_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_we_o |-> $past(wr_valid_i && offset_i == CTRL_OFF));

  // R8: without a control write the fields do not move
  p_fields_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_i && offset_i == CTRL_OFF) |=> ($stable(phy_addr_o) && $stable(phy_wdata_o) && !phy_we_o));

  // R6: status read has only the nibble field populated
  p_stat_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && offset_i == STAT_OFF) |=> ((rdata_o & ~(32'hF << RD_LSB)) == 32'h0));

  // R7: control read has zero upper half
  p_ctrl_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && offset_i == CTRL_OFF) |=> (rdata_o[BUS_W-1:HALF_W] == '0));

  // R10: read data holds when idle
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> $stable(rdata_o));
endmodule

bind phy_cfg_bridge pcb_bridge_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .rd_valid_i (rd_valid_i),
  .offset_i   (offset_i),
  .rdata_o    (rdata_o),
  .phy_addr_o (phy_addr_o),
  .phy_wdata_o(phy_wdata_o),
  .phy_we_o   (phy_we_o)
);

// File: tb/phy_cfg_bridge_test.sv
module phy_cfg_bridge_test;
  localparam logic [15:0] CTRL = 16'hE220;
  localparam logic [15:0] STAT = 16'hE2A4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [15:0] offset_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [5:0]  phy_addr_o;
  logic [3:0]  phy_wdata_o;
  logic        phy_we_o;
  logic [3:0]  phy_rdata_i;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  phy_cfg_bridge uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .rd_valid_i(rd_valid_i),
    .offset_i(offset_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .phy_addr_o(phy_addr_o),
    .phy_wdata_o(phy_wdata_o), .phy_we_o(phy_we_o), .phy_rdata_i(phy_rdata_i)
  );

  // PHY model: 64 nibbles, special read views at 0x10 and 0x12
  logic [3:0] mem [64];
  always_ff @(posedge clk_i) begin
    if (phy_we_o) mem[phy_addr_o] <= phy_wdata_o;
    if (phy_we_o) pulses <= pulses + 1;
  end
  always_comb begin
    if (phy_addr_o == 6'h10)      phy_rdata_i = {2'b00, mem[6'h10][3], 1'b0};
    else if (phy_addr_o == 6'h12) phy_rdata_i = {1'b0, ~mem[6'h12][3], 2'b00};
    else                          phy_rdata_i = mem[phy_addr_o];
  end

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] off, input logic [31:0] d);
    @(negedge clk_i);
    wr_valid_i = 1'b1; offset_i = off; wdata_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] off, output logic [31:0] d);
    @(negedge clk_i);
    rd_valid_i = 1'b1; offset_i = off;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    d = rdata_o;
  endtask

  function automatic logic [3:0] nib(input int a);
    return 4'((a * 5 + 3) & 15);
  endfunction

  initial begin
    logic [31:0] rd;
    logic [15:0] shadow;
    int exp_p;
    for (int i = 0; i < 64; i++) mem[i] = 4'h0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(rdata_o == 0 && phy_addr_o == 0 && phy_wdata_o == 0 && phy_we_o == 0, "R1 reset outputs",
          {21'b0, phy_we_o, phy_wdata_o, phy_addr_o}, 32'h0);
    rst_ni = 1'b1;
    bus_rd(CTRL, rd);
    check(rd == 32'h0, "R1 ctrl after reset", rd, 32'h0);

    // R3/R4/R6: full write sequence at every address
    for (int a = 0; a < 64; a++) begin
      exp_p = pulses;
      bus_wr(CTRL, {16'h07FE, 5'b0, nib(a), 6'(a), 1'b0});
      check(phy_addr_o == 6'(a) && phy_wdata_o == nib(a), "R3 fields",
            {22'b0, phy_wdata_o, phy_addr_o}, {22'b0, nib(a), 6'(a)});
      check(phy_we_o == 1'b0, "R3 no pulse on load", {31'b0, phy_we_o}, 32'h0);
      bus_wr(CTRL, 32'h0001_0001);
      check(phy_we_o == 1'b1, "R4 pulse after rise", {31'b0, phy_we_o}, 32'h1);
      @(negedge clk_i);
      check(phy_we_o == 1'b0, "R4 pulse one cycle", {31'b0, phy_we_o}, 32'h0);
      bus_wr(CTRL, 32'h0001_0001);
      repeat (2) @(negedge clk_i);
      check(pulses == exp_p + 1, "R5 held strobe", pulses, exp_p + 1);
      bus_wr(CTRL, 32'h0001_0000);
      check(phy_we_o == 1'b0, "R4 no pulse on fall", {31'b0, phy_we_o}, 32'h0);
    end
    for (int a = 0; a < 64; a++) begin
      logic [3:0] e;
      bus_wr(CTRL, {16'h007E, 9'b0, 6'(a), 1'b0});
      if (a == 16)      e = {2'b00, nib(a)[3], 1'b0};
      else if (a == 18) e = {1'b0, ~nib(a)[3], 2'b00};
      else              e = nib(a);
      bus_rd(STAT, rd);
      check(rd == {20'b0, e, 8'b0}, "R6 status read", rd, {20'b0, e, 8'b0});
    end

    // R2/R7 masked write sweep against shadow
    bus_rd(CTRL, rd);
    shadow = rd[15:0];
    for (int k = 0; k < 32; k++) begin
      logic [15:0] m, v;
      m = 16'(16'h1 << (k % 16)) ^ 16'(k * 16'h0911);
      v = 16'(k * 16'h3A5D) ^ 16'hC3C3;
      exp_p = pulses + ((~shadow[0] & m[0] & v[0]) ? 1 : 0);
      shadow = (shadow & ~m) | (v & m);
      bus_wr(CTRL, {m, v});
      @(negedge clk_i);
      bus_rd(CTRL, rd);
      check(rd == {16'b0, shadow}, "R2 R7 masked write", rd, {16'b0, shadow});
      check(pulses == exp_p, "R4 R5 sweep pulses", pulses, exp_p);
    end

    // R9 field load with strobe already high
    bus_wr(CTRL, 32'hFFFF_0001);
    @(negedge clk_i);
    exp_p = pulses;
    bus_wr(CTRL, 32'h07FE_0000 | 32'h0000_0554);
    @(negedge clk_i);
    bus_rd(CTRL, rd);
    check(rd == 32'h0000_0555, "R9 field load keeps strobe", rd, 32'h0000_0555);
    check(pulses == exp_p, "R9 no pulse", pulses, exp_p);

    // R8 foreign offsets
    bus_wr(16'hE224, 32'hFFFF_0000);
    bus_wr(STAT, 32'hFFFF_0000);
    @(negedge clk_i);
    bus_rd(CTRL, rd);
    check(rd == 32'h0000_0555, "R8 foreign write ignored", rd, 32'h0000_0555);
    check(pulses == exp_p, "R8 no pulse", pulses, exp_p);
    bus_rd(16'h0000, rd);
    check(rd == 32'h0, "R8 unknown read zero", rd, 32'h0);

    // R10 hold
    bus_rd(CTRL, rd);
    repeat (3) @(negedge clk_i);
    check(rdata_o == 32'h0000_0555, "R10 read data holds", rdata_o, 32'h0000_0555);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule